// File: doc/BRIEF.md
# Boost Frequency Governor Datapath

This block turns the results of an activity monitor into a requested memory-clock frequency. Each call processes one of two monitor channels. It takes that channel's consecutive-event flags, its latest average activity count, the present and maximum clock frequencies in kHz, and a frequency floor that the processor speed implies. From these it updates the channel's boost value and recomputes the channel's raw and average watermark values. It also hands back new enable bits for the channel's two consecutive-event detectors. The enable bits give the monitor hysteresis, so the boost does not keep climbing once it has reached the ceiling and does not keep decaying once it has reached zero.

A call begins with a one-cycle `start` pulse while the block is idle. All arithmetic runs through one shared shift-and-add multiplier and restoring divider. A call always takes the same number of cycles and ends with a one-cycle `done` pulse. The block keeps a boost value and a target for each channel, and it presents the larger of the two targets as the frequency request. Every division truncates. The sampling period is 12 ms.

Top module: `boost_governor`

## Requirements
- R1: After synchronous reset both boost values and both targets are 0, and `freq_target`, `boost_out`, `busy` and `done` are 0.
- R2: A `start` taken while idle captures all inputs. `busy` then stays high until `done` pulses for one cycle, exactly 11*(2*DW+1)+1 clock edges after the capturing edge (716 at DW=32). A `start` while busy is ignored.
- R3: With `ev_upper`=1, the new boost is boost*up_coeff/100 + 16000. If that value is at least `max_freq`, the boost becomes `max_freq` and `en_above`=0; otherwise `en_above`=1. `en_below`=1 in both cases (subject to R7).
- R4: With `ev_lower`=1 and `ev_upper`=0, the new boost is boost*down_coeff/100. If that value is below 8000, the boost becomes 0 and `en_below`=0 (subject to R7); otherwise `en_below`=1. `en_above`=1.
- R5: With neither flag set, the boost is unchanged and `en_above`/`en_below` equal `en_above_in`/`en_below_in`. When both flags are set, the upper event wins.
- R6: `ch`=0 selects up/down coefficients 200/50 and up/down thresholds 60/40. `ch`=1 selects 800/90 and 27/10. Only the selected channel's boost and target change.
- R7: On channel 1 only, an average of 50000 or more forces `en_below`=1. A smaller average together with a new boost of 0 forces `en_below`=0.
- R8: `wm_upper` = cur_freq*12*up_threshold/100 and `wm_lower` = cur_freq*12*down_threshold/100.
- R9: With band = (max_freq*6/1000)*12, `avg_wm_upper` = avg + band and `avg_wm_lower` = max(avg, band) - band.
- R10: The channel target is (avg/12)*(10000/up_threshold)/100 + new boost. On channel 1, when avg is at least 50000, the target is raised to `cpu_floor` if `cpu_floor` is larger.
- R11: `freq_target` is the larger of the two stored channel targets. It and `boost_out` change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a call (taken only when idle) |
| ch | input | 1 | Channel to process (0 or 1) |
| ev_upper | input | 1 | Consecutive-upper event seen |
| ev_lower | input | 1 | Consecutive-lower event seen |
| en_above_in | input | 1 | Present above-detector enable |
| en_below_in | input | 1 | Present below-detector enable |
| avg_in | input | DW | Channel average activity count |
| cur_freq | input | DW | Present clock frequency, kHz |
| max_freq | input | DW | Maximum clock frequency, kHz |
| cpu_floor | input | DW | Floor frequency derived from processor speed, kHz |
| busy | output | 1 | Call in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| en_above | output | 1 | New above-detector enable |
| en_below | output | 1 | New below-detector enable |
| wm_upper | output | DW | Raw upper watermark |
| wm_lower | output | DW | Raw lower watermark |
| avg_wm_upper | output | DW | Average upper watermark |
| avg_wm_lower | output | DW | Average lower watermark |
| boost_out | output | DW | New boost of the processed channel |
| freq_target | output | DW | Larger of the two channel targets |

## Verification
The bench builds the block with its default parameters: DW=32, a 12 ms period, a 16000 kHz step, a band of 6 per mille, the two channels' coefficient and threshold sets, and a dependency threshold of 50000. With a 2 GHz ceiling, channel 0 reaches the clamp after seven upper events and snaps to zero after eight lower events, so both hysteresis edges come up in short directed runs. Random averages are spread around 50000 so that the channel-1 forcing and the floor are exercised in both directions. The 64-step iterations make the latency long but fixed, and the bench checks it on every call.

// File: rtl/boost_governor.sv
module boost_governor #(
  parameter int DW      = 32,
  parameter int PERIOD  = 12,
  parameter int STEP    = 16000,
  parameter int BAND_PM = 6,
  parameter int UP_C0   = 200,
  parameter int DN_C0   = 50,
  parameter int UP_T0   = 60,
  parameter int DN_T0   = 40,
  parameter int UP_C1   = 800,
  parameter int DN_C1   = 90,
  parameter int UP_T1   = 27,
  parameter int DN_T1   = 10,
  parameter int DEP1    = 50000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ch,
  input  logic          ev_upper,
  input  logic          ev_lower,
  input  logic          en_above_in,
  input  logic          en_below_in,
  input  logic [DW-1:0] avg_in,
  input  logic [DW-1:0] cur_freq,
  input  logic [DW-1:0] max_freq,
  input  logic [DW-1:0] cpu_floor,
  output logic          busy,
  output logic          done,
  output logic          en_above,
  output logic          en_below,
  output logic [DW-1:0] wm_upper,
  output logic [DW-1:0] wm_lower,
  output logic [DW-1:0] avg_wm_upper,
  output logic [DW-1:0] avg_wm_lower,
  output logic [DW-1:0] boost_out,
  output logic [DW-1:0] freq_target
);
  localparam int AW   = 2 * DW;
  localparam int CW   = $clog2(AW);
  localparam int NOPS = 11;
  localparam int SUS0 = 10000 / UP_T0;
  localparam int SUS1 = 10000 / UP_T1;
  localparam int HALF = STEP / 2;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t state;

  logic [3:0]    idx;
  logic [CW-1:0] cnt;
  logic          ld;
  logic [AW-1:0] acc, opa, opb, last;
  logic          c_ch, c_up, c_lo, c_ea, c_eb;
  logic [DW-1:0] c_avg, c_cur, c_max, c_fl;
  logic [DW-1:0] qb, bq, tq;
  logic [DW-1:0] boost_r [2];
  logic [DW-1:0] tgt_r [2];

  logic [DW-1:0] k_uc, k_dc, k_ut, k_dt, k_sus, k_coef;
  assign k_uc   = c_ch ? DW'(UP_C1) : DW'(UP_C0);
  assign k_dc   = c_ch ? DW'(DN_C1) : DW'(DN_C0);
  assign k_ut   = c_ch ? DW'(UP_T1) : DW'(UP_T0);
  assign k_dt   = c_ch ? DW'(DN_T1) : DW'(DN_T0);
  assign k_sus  = c_ch ? DW'(SUS1)  : DW'(SUS0);
  assign k_coef = c_up ? k_uc : (c_lo ? k_dc : DW'(100));

  logic          op_mul;
  logic [AW-1:0] op_a, op_b;
  always_comb begin
    op_mul = 1'b0;
    op_a   = last;
    op_b   = AW'(100);
    case (idx)
      4'd0:  begin op_mul = 1'b1; op_a = AW'(boost_r[c_ch]); op_b = AW'(k_coef); end
      4'd2:  begin op_mul = 1'b1; op_a = AW'(c_cur); op_b = AW'(k_ut * DW'(PERIOD)); end
      4'd4:  begin op_mul = 1'b1; op_a = AW'(c_cur); op_b = AW'(k_dt * DW'(PERIOD)); end
      4'd6:  begin op_mul = 1'b1; op_a = AW'(c_max); op_b = AW'(BAND_PM); end
      4'd7:  op_b = AW'(1000);
      4'd8:  begin op_a = AW'(c_avg); op_b = AW'(PERIOD); end
      4'd9:  begin op_mul = 1'b1; op_b = AW'(k_sus); end
      default: ;
    endcase
  end

  logic [AW-1:0] dv_t, acc_n, opa_n, opb_n;
  logic          dv_ge;
  assign dv_t  = {acc[AW-2:0], opa[AW-1]};
  assign dv_ge = dv_t >= opb;
  assign acc_n = op_mul ? (opb[0] ? acc + opa : acc) : (dv_ge ? dv_t - opb : dv_t);
  assign opa_n = op_mul ? {opa[AW-2:0], 1'b0} : {opa[AW-2:0], dv_ge};
  assign opb_n = op_mul ? {1'b0, opb[AW-1:1]} : opb;

  logic [AW-1:0] res;
  assign res = op_mul ? acc_n : opa_n;

  logic [DW:0]   up_sum;
  logic          dep;
  logic [DW-1:0] nb, band, tsum, tfin;
  logic          n_ea, n_eb, f_eb;
  assign up_sum = {1'b0, qb} + (DW+1)'(STEP);
  assign dep    = c_ch && (c_avg >= DW'(DEP1));
  always_comb begin
    nb = qb; n_ea = c_ea; n_eb = c_eb;
    if (c_up) begin
      n_eb = 1'b1;
      if (up_sum >= {1'b0, c_max}) begin nb = c_max; n_ea = 1'b0; end
      else begin nb = up_sum[DW-1:0]; n_ea = 1'b1; end
    end else if (c_lo) begin
      n_ea = 1'b1;
      if (qb < DW'(HALF)) begin nb = '0; n_eb = 1'b0; end
      else n_eb = 1'b1;
    end
  end
  assign f_eb = dep ? 1'b1 : ((c_ch && nb == '0) ? 1'b0 : n_eb);
  assign band = bq * DW'(PERIOD);
  assign tsum = tq + nb;
  assign tfin = (dep && c_fl > tsum) ? c_fl : tsum;

  assign busy        = state != S_IDLE;
  assign freq_target = (tgt_r[0] > tgt_r[1]) ? tgt_r[0] : tgt_r[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      idx <= '0; cnt <= '0; ld <= 1'b0;
      acc <= '0; opa <= '0; opb <= '0; last <= '0;
      c_ch <= 1'b0; c_up <= 1'b0; c_lo <= 1'b0; c_ea <= 1'b0; c_eb <= 1'b0;
      c_avg <= '0; c_cur <= '0; c_max <= '0; c_fl <= '0;
      qb <= '0; bq <= '0; tq <= '0;
      boost_r[0] <= '0; boost_r[1] <= '0;
      tgt_r[0] <= '0; tgt_r[1] <= '0;
      done <= 1'b0; en_above <= 1'b0; en_below <= 1'b0;
      wm_upper <= '0; wm_lower <= '0; avg_wm_upper <= '0; avg_wm_lower <= '0;
      boost_out <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          c_ch <= ch; c_up <= ev_upper; c_lo <= ev_lower;
          c_ea <= en_above_in; c_eb <= en_below_in;
          c_avg <= avg_in; c_cur <= cur_freq; c_max <= max_freq; c_fl <= cpu_floor;
          idx <= '0; ld <= 1'b1;
          state <= S_RUN;
        end
        S_RUN: if (ld) begin
          acc <= '0; opa <= op_a; opb <= op_b; cnt <= '0; ld <= 1'b0;
        end else begin
          acc <= acc_n; opa <= opa_n; opb <= opb_n;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(AW - 1)) begin
            last <= res;
            case (idx)
              4'd1:  qb       <= res[DW-1:0];
              4'd3:  wm_upper <= res[DW-1:0];
              4'd5:  wm_lower <= res[DW-1:0];
              4'd7:  bq       <= res[DW-1:0];
              4'd10: tq       <= res[DW-1:0];
              default: ;
            endcase
            if (idx == 4'(NOPS - 1)) state <= S_FIN;
            else begin idx <= idx + 1'b1; ld <= 1'b1; end
          end
        end
        S_FIN: begin
          boost_r[c_ch] <= nb;
          tgt_r[c_ch]   <= tfin;
          boost_out     <= nb;
          en_above      <= n_ea;
          en_below      <= f_eb;
          avg_wm_upper  <= c_avg + band;
          avg_wm_lower  <= (c_avg >= band) ? c_avg - band : '0;
          done          <= 1'b1;
          state         <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module boost_governor_chk #(parameter int DW = 32) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] boost_out,
  input logic [DW-1:0] freq_target
);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst) busy |=> (busy || done));
  // R11
  target_at_done_chk: assert property (@(posedge clk) disable iff (rst) !$stable(freq_target) |-> done);
  // R11
  boost_at_done_chk: assert property (@(posedge clk) disable iff (rst) !$stable(boost_out) |-> done);
endmodule

bind boost_governor boost_governor_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .boost_out(boost_out), .freq_target(freq_target)
);

// File: tb/tb_boost_governor.sv
module tb_boost_governor;
  localparam int DW  = 32;
  localparam int LAT = 11 * (2 * DW + 1) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, ch = 1'b0, ev_upper = 1'b0, ev_lower = 1'b0;
  logic en_above_in = 1'b0, en_below_in = 1'b0;
  logic [DW-1:0] avg_in = '0, cur_freq = '0, max_freq = '0, cpu_floor = '0;
  logic busy, done, en_above, en_below;
  logic [DW-1:0] wm_upper, wm_lower, avg_wm_upper, avg_wm_lower, boost_out, freq_target;

  always #5 clk = ~clk;

  boost_governor dut (
    .clk(clk), .rst(rst), .start(start), .ch(ch), .ev_upper(ev_upper), .ev_lower(ev_lower),
    .en_above_in(en_above_in), .en_below_in(en_below_in), .avg_in(avg_in),
    .cur_freq(cur_freq), .max_freq(max_freq), .cpu_floor(cpu_floor),
    .busy(busy), .done(done), .en_above(en_above), .en_below(en_below),
    .wm_upper(wm_upper), .wm_lower(wm_lower), .avg_wm_upper(avg_wm_upper),
    .avg_wm_lower(avg_wm_lower), .boost_out(boost_out), .freq_target(freq_target)
  );

  int errors = 0, checks = 0;
  longint bm [2] = '{0, 0};
  longint tm [2] = '{0, 0};
  localparam longint M32 = 64'hFFFF_FFFF;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input bit c, input bit up, input bit lo, input bit ea, input bit eb,
                     input longint avg, input longint cur, input longint mx, input longint fl,
                     input bit poke);
    longint uc, dc, ut, dt, sus, coef, qb, t, nb, band, alo, tq, tg, e_ea, e_eb;
    int k;
    string tb;
    uc = c ? 800 : 200; dc = c ? 90 : 50; ut = c ? 27 : 60; dt = c ? 10 : 40;
    sus = 10000 / ut;
    coef = up ? uc : (lo ? dc : 100);
    qb = (bm[c] * coef / 100) & M32;
    e_ea = ea; e_eb = eb; nb = qb;
    if (up) begin
      t = qb + 16000; e_eb = 1;
      if (t >= mx) begin nb = mx; e_ea = 0; end else begin nb = t; e_ea = 1; end
    end else if (lo) begin
      e_ea = 1;
      if (qb < 8000) begin nb = 0; e_eb = 0; end else e_eb = 1;
    end
    if (c && avg >= 50000) e_eb = 1;
    else if (c && nb == 0) e_eb = 0;
    band = (mx * 6 / 1000) * 12;
    alo = (avg >= band) ? avg - band : 0;
    tq = ((avg / 12) * sus / 100) & M32;
    tg = (tq + nb) & M32;
    if (c && avg >= 50000 && fl > tg) tg = fl;
    bm[c] = nb; tm[c] = tg;
    tb = up ? "R3" : (lo ? "R4" : "R5");

    @(negedge clk);
    start = 1'b1; ch = c; ev_upper = up; ev_lower = lo; en_above_in = ea; en_below_in = eb;
    avg_in = DW'(avg); cur_freq = DW'(cur); max_freq = DW'(mx); cpu_floor = DW'(fl);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    do begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (poke && k == 100) begin
        start = 1'b1; ch = ~c; ev_upper = 1'b1; avg_in = '1; max_freq = 32'd5;
      end
      if (poke && k == 101) start = 1'b0;
    end while (!done && k < 3000);
    check("R2 latency", k, LAT);
    check({tb, " boost"}, boost_out, nb);
    check({tb, " en_above"}, en_above, e_ea);
    check(c ? "R7 en_below" : {tb, " en_below"}, en_below, e_eb);
    check("R8 R6 wm_upper", wm_upper, (cur * 12 * ut / 100) & M32);
    check("R8 R6 wm_lower", wm_lower, (cur * 12 * dt / 100) & M32);
    check("R9 avg_wm_upper", avg_wm_upper, (avg + band) & M32);
    check("R9 avg_wm_lower", avg_wm_lower, alo);
    check("R10 R11 freq_target", freq_target, (tm[0] > tm[1]) ? tm[0] : tm[1]);
    if (poke) begin
      @(negedge clk);
      check("R2 busy after ignored start", busy, 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 freq_target", freq_target, 0);
    check("R1 boost_out", boost_out, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);

    // R3 growth until clamp on channel 0
    for (int i = 0; i < 7; i++) run(0, 1, 0, 1, 1, 24000000, 2000000, 2000000, 0, 0);
    check("R3 clamped boost", boost_out, 2000000);
    check("R3 above disabled at clamp", en_above, 0);
    // R4 decay until snap
    for (int i = 0; i < 8; i++) run(0, 0, 1, 0, 1, 300000, 1000000, 2000000, 0, 0);
    check("R4 snapped boost", boost_out, 0);
    check("R4 below disabled at zero", en_below, 0);
    // R5 both flags: upper wins; no event passes enables
    run(0, 1, 1, 0, 0, 500000, 800000, 2000000, 0, 0);
    run(0, 0, 0, 0, 1, 500000, 800000, 2000000, 0, 0);
    check("R5 enables pass through", {en_above, en_below}, 2'b01);
    // R7 dependency on channel 1
    run(1, 0, 0, 1, 0, 60000, 800000, 2000000, 0, 0);
    check("R7 forced on", en_below, 1);
    run(1, 0, 0, 1, 1, 1000, 800000, 2000000, 0, 0);
    check("R7 forced off", en_below, 0);
    // R10 floor on channel 1, ignored on channel 0
    run(1, 0, 0, 1, 1, 60000, 800000, 2000000, 3000000, 0);
    check("R10 floor raises target", freq_target, 3000000);
    run(0, 0, 0, 1, 1, 60000, 800000, 2000000, 3900000, 0);
    // R9 average below band
    run(0, 0, 0, 1, 1, 100, 800000, 2000000, 0, 0);
    check("R9 lower floor zero", avg_wm_lower, 0);
    // R2 start while busy ignored
    run(1, 1, 0, 1, 1, 52000, 900000, 1500000, 100000, 1);

    for (int i = 0; i < 40; i++) begin
      bit c, up, lo;
      longint avg;
      c = 1'($urandom()); up = 1'($urandom()); lo = 1'($urandom());
      avg = ($urandom_range(3, 0) == 0) ? longint'($urandom_range(80000, 20000))
                                        : longint'($urandom_range(60000000, 0));
      run(c, up, lo, 1'($urandom()), 1'($urandom()), avg,
          longint'($urandom_range(4000000, 100000)), longint'($urandom_range(4000000, 200000)),
          longint'($urandom_range(4000000, 0)), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule